// File: doc/BRIEF.md
# EDO DRAM Controller with CBR Refresh

This block sits between a simple host request port and a 16-bit asynchronous EDO DRAM. The host offers one request at a time: a word address, a read/write flag, two byte enables and write data. The controller splits the address into a row and a column. It opens the row with RAS and then issues one CAS cycle for each access. While later requests keep hitting the open row, RAS stays low and only CAS toggles (EDO page mode).

An internal interval timer raises a refresh request. When that request is pending, no new host requests are taken. Any open row is closed, and a CAS-before-RAS refresh is run: CAS goes low with RAS high, then RAS goes low. Every strobe width and gap is a whole number of system clocks set by parameters. All DRAM pins are driven from registers. The data pins are split into an output bus, an output-enable and an input bus. A pad ring or a testbench joins them.

Top module: `edo_dram_ctrl`

## Requirements
- R1: The word address is split so that row = `req_addr[21:9]` is driven on `dram_addr` while RAS falls, and column = `req_addr[8:0]` (upper address bits zero) is driven while CAS falls.
- R2: On a write, `req_be[0]` selects the low byte (`dram_lcas_n`, data bits 7:0) and `req_be[1]` selects the high byte (`dram_ucas_n`, bits 15:8). Only the enabled lanes' CAS go low, and the other byte in the DRAM is unchanged.
- R3: A write is an early write. WE is low and the data bus is driven no later than the CAS falling edge, and OE stays high for the whole write.
- R4: A read holds WE high, drives OE low, and takes both CAS low regardless of the byte enables. The data captured at the end of the CAS-low window is returned on `rdata` with a single-cycle `rdata_valid` pulse.
- R5: Consecutive requests to the same row are served with RAS held low, with one CAS cycle per access and no new row activation.
- R6: A request to a different row raises RAS. RAS then stays high for at least `T_RP` clock cycles before it falls again.
- R7: One CAS-before-RAS refresh is run every `REF_INTERVAL` clock cycles. CAS goes low while RAS is high, with WE high and the data bus not driven.
- R8: While a refresh is pending, no host request is accepted. An open row is closed and the refresh is run first, and host traffic then resumes with no request lost.
- R9: During and right after reset, RAS, both CAS, WE and OE are high, the data bus is not driven, and `rdata_valid` is low.
- R10: CAS falls no sooner than `T_RCD` cycles after RAS falls, and each CAS-low window during an access lasts `T_CAS` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this clock edge when valid is high |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address (row in the upper bits) |
| req_be | input | 2 | Byte enables for writes, bit 0 = low byte |
| req_wdata | input | 16 | Write data |
| rdata | output | 16 | Read data |
| rdata_valid | output | 1 | One-cycle pulse marking `rdata` |
| dram_addr | output | 13 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | High-byte column strobe, active low |
| dram_lcas_n | output | 1 | Low-byte column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_out | output | 16 | Data driven towards the DRAM |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 16 | Data returned by the DRAM |

## Verification
The assertions assume that the host holds its request fields steady while `req_valid` is high and unanswered. They also assume the DRAM returns valid data within the CAS-low window that the parameters set. The bench drives requests only from tasks that keep every field fixed until the handshake edge. Its DRAM model places read data 20 ns after CAS falls, which is well inside the 32 ns default window. The refresh checks assume traffic never holds the bus for longer than a refresh interval. Every scenario is a sequence of single requests, and none of them lasts long enough to break that.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    parameter int ROW_W  = 13;
    parameter int COL_W  = 9;
    parameter int DQ_W   = 16;
    parameter int LANES  = 2;
    localparam int ADDR_W = ROW_W + COL_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_CAS,
        ST_OPEN,
        ST_PRE,
        ST_RCAS,
        ST_RRAS
    } seq_st_e;

    typedef struct packed {
        logic             we;
        logic [LANES-1:0] be;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
        logic [DQ_W-1:0]  wdata;
    } op_t;

    typedef struct packed {
        logic ras_n;
        logic ucas_n;
        logic lcas_n;
        logic we_n;
        logic oe_n;
        logic dq_oe;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ras_n: 1'b1, ucas_n: 1'b1, lcas_n: 1'b1,
                                        we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    function automatic strobe_t strobe_for(seq_st_e st, op_t op);
        strobe_t s;
        s = STROBE_IDLE;
        case (st)
            ST_ACT, ST_OPEN: s.ras_n = 1'b0;
            ST_CAS: begin
                s.ras_n = 1'b0;
                if (op.we) begin
                    s.lcas_n = ~op.be[0];
                    s.ucas_n = ~op.be[1];
                    s.we_n   = 1'b0;
                    s.dq_oe  = 1'b1;
                end else begin
                    s.lcas_n = 1'b0;
                    s.ucas_n = 1'b0;
                    s.oe_n   = 1'b0;
                end
            end
            ST_RCAS: begin
                s.lcas_n = 1'b0;
                s.ucas_n = 1'b0;
            end
            ST_RRAS: begin
                s.ras_n  = 1'b0;
                s.lcas_n = 1'b0;
                s.ucas_n = 1'b0;
            end
            default: s = STROBE_IDLE;
        endcase
        return s;
    endfunction

    function automatic logic [ROW_W-1:0] addr_for(seq_st_e st, op_t op);
        if (st == ST_CAS)
            return {{(ROW_W-COL_W){1'b0}}, op.col};
        return op.row;
    endfunction

endpackage

// File: rtl/edo_addr_map.sv
`timescale 1ns/1ps
module edo_addr_map
    import edo_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [ROW_W-1:0]  open_row,
    input  logic              open_vld,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col,
    output logic              row_hit
);
    assign row     = addr[ADDR_W-1:COL_W];
    assign col     = addr[COL_W-1:0];
    assign row_hit = open_vld && (row == open_row);
endmodule

// File: rtl/edo_refresh_timer.sv
`timescale 1ns/1ps
module edo_refresh_timer #(
    parameter int REF_INTERVAL = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic done,
    output logic pend
);
    localparam int TW = (REF_INTERVAL > 1) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] cnt_q;
    logic          fire;

    assign fire = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
            pend  <= 1'b0;
        end else begin
            cnt_q <= fire ? RELOAD : cnt_q - 1'b1;
            pend  <= fire | (pend & ~done);
        end
    end
endmodule

// File: rtl/edo_seq.sv
`timescale 1ns/1ps
module edo_seq
    import edo_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 4,
    parameter int T_CP      = 2,
    parameter int T_RP      = 4,
    parameter int T_CSR     = 1,
    parameter int T_REF_RAS = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_we,
    input  logic [LANES-1:0] req_be,
    input  logic [DQ_W-1:0]  req_wdata,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             row_hit,
    input  logic             ref_pend,
    input  logic [DQ_W-1:0]  dq_in,
    output logic             req_ready,
    output seq_st_e          st_d,
    output op_t              op_d,
    output logic [ROW_W-1:0] open_row,
    output logic             open_vld,
    output logic             ref_done,
    output logic [DQ_W-1:0]  rdata,
    output logic             rdata_valid
);
    localparam int M1 = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int M2 = (T_CP > T_RP) ? T_CP : T_RP;
    localparam int M3 = (T_CSR > T_REF_RAS) ? T_CSR : T_REF_RAS;
    localparam int M4 = (M1 > M2) ? M1 : M2;
    localparam int MAX_T = (M4 > M3) ? M4 : M3;
    localparam int CW = $clog2(MAX_T + 1);

    seq_st_e       st_q;
    op_t           op_q, req_op;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          cnt_done, capture;

    assign cnt_done = (cnt_q == '0);
    assign open_row = op_q.row;
    assign open_vld = (st_q == ST_OPEN);

    always_comb begin
        req_op.we    = req_we;
        req_op.be    = req_be;
        req_op.row   = req_row;
        req_op.col   = req_col;
        req_op.wdata = req_wdata;
    end

    always_comb begin
        st_d      = st_q;
        op_d      = op_q;
        cnt_d     = cnt_done ? cnt_q : cnt_q - 1'b1;
        req_ready = 1'b0;
        ref_done  = 1'b0;
        capture   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (ref_pend) begin
                    st_d  = ST_RCAS;
                    cnt_d = CW'(T_CSR - 1);
                end else if (req_valid) begin
                    req_ready = 1'b1;
                    op_d      = req_op;
                    st_d      = ST_ACT;
                    cnt_d     = CW'(T_RCD - 1);
                end
            end
            ST_ACT: if (cnt_done) begin
                st_d  = ST_CAS;
                cnt_d = CW'(T_CAS - 1);
            end
            ST_CAS: if (cnt_done) begin
                capture = ~op_q.we;
                st_d    = ST_OPEN;
                cnt_d   = CW'(T_CP - 1);
            end
            ST_OPEN: if (cnt_done) begin
                if (ref_pend) begin
                    st_d  = ST_PRE;
                    cnt_d = CW'(T_RP - 1);
                end else if (req_valid && row_hit) begin
                    req_ready = 1'b1;
                    op_d      = req_op;
                    st_d      = ST_CAS;
                    cnt_d     = CW'(T_CAS - 1);
                end else if (req_valid) begin
                    st_d  = ST_PRE;
                    cnt_d = CW'(T_RP - 1);
                end
            end
            ST_PRE: if (cnt_done) st_d = ST_IDLE;
            ST_RCAS: if (cnt_done) begin
                st_d  = ST_RRAS;
                cnt_d = CW'(T_REF_RAS - 1);
            end
            ST_RRAS: if (cnt_done) begin
                ref_done = 1'b1;
                st_d     = ST_PRE;
                cnt_d    = CW'(T_RP - 1);
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            op_q        <= '0;
            cnt_q       <= '0;
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            st_q        <= st_d;
            op_q        <= op_d;
            cnt_q       <= cnt_d;
            rdata_valid <= capture;
            if (capture) rdata <= dq_in;
        end
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
`timescale 1ns/1ps
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 4,
    parameter int T_CP         = 2,
    parameter int T_RP         = 4,
    parameter int T_CSR        = 1,
    parameter int T_REF_RAS    = 7,
    parameter int REF_INTERVAL = 1950
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_be,
    input  logic [DQ_W-1:0]   req_wdata,
    output logic [DQ_W-1:0]   rdata,
    output logic              rdata_valid,
    output logic [ROW_W-1:0]  dram_addr,
    output logic              dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic              dram_we_n,
    output logic              dram_oe_n,
    output logic [DQ_W-1:0]   dram_dq_out,
    output logic              dram_dq_oe,
    input  logic [DQ_W-1:0]   dram_dq_in
);
    logic [ROW_W-1:0] req_row, open_row;
    logic [COL_W-1:0] req_col;
    logic             row_hit, open_vld, ref_pend, ref_done;
    seq_st_e          st_d;
    op_t              op_d;
    strobe_t          pins_q;

    edo_addr_map u_map (
        .addr     (req_addr),
        .open_row (open_row),
        .open_vld (open_vld),
        .row      (req_row),
        .col      (req_col),
        .row_hit  (row_hit)
    );

    edo_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_refresh (
        .clk  (clk),
        .rst  (rst),
        .done (ref_done),
        .pend (ref_pend)
    );

    edo_seq #(
        .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
        .T_RP(T_RP), .T_CSR(T_CSR), .T_REF_RAS(T_REF_RAS)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_be      (req_be),
        .req_wdata   (req_wdata),
        .req_row     (req_row),
        .req_col     (req_col),
        .row_hit     (row_hit),
        .ref_pend    (ref_pend),
        .dq_in       (dram_dq_in),
        .req_ready   (req_ready),
        .st_d        (st_d),
        .op_d        (op_d),
        .open_row    (open_row),
        .open_vld    (open_vld),
        .ref_done    (ref_done),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    // Pin register: decoded from the next state so pins line up with the state register.
    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q      <= STROBE_IDLE;
            dram_addr   <= '0;
            dram_dq_out <= '0;
        end else begin
            pins_q      <= strobe_for(st_d, op_d);
            dram_addr   <= addr_for(st_d, op_d);
            dram_dq_out <= op_d.wdata;
        end
    end

    assign dram_ras_n  = pins_q.ras_n;
    assign dram_ucas_n = pins_q.ucas_n;
    assign dram_lcas_n = pins_q.lcas_n;
    assign dram_we_n   = pins_q.we_n;
    assign dram_oe_n   = pins_q.oe_n;
    assign dram_dq_oe  = pins_q.dq_oe;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
`timescale 1ns/1ps
module edo_dram_ctrl_chk
    import edo_pkg::*;
#(
    parameter int T_RCD = 3,
    parameter int T_RP  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             ras_n,
    input logic             ucas_n,
    input logic             lcas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe,
    input logic [ROW_W-1:0] addr,
    input logic             rdata_valid,
    input logic             req_ready,
    input logic             ref_pend
);
    localparam int CW = $clog2(T_RCD + T_RP + 2);
    localparam logic [CW-1:0] SAT = CW'(T_RCD + T_RP + 1);

    logic [CW-1:0] hi_cnt, lo_cnt;
    logic          any_cas;

    assign any_cas = ~lcas_n | ~ucas_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt <= SAT;
            lo_cnt <= SAT;
        end else begin
            if (ras_n) hi_cnt <= (hi_cnt == SAT) ? SAT : hi_cnt + 1'b1;
            else       hi_cnt <= '0;
            if (!ras_n) lo_cnt <= (lo_cnt == SAT) ? SAT : lo_cnt + 1'b1;
            else        lo_cnt <= '0;
        end
    end

    // R9: standby means no drive on the data bus
    p_standby_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (ras_n && ucas_n && lcas_n) |-> (!dq_oe && oe_n));

    // R3: output enable and write enable are never both active
    p_no_oe_during_write_r3: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n && !dq_oe));

    // R6: RAS precharge lasts at least T_RP cycles
    p_precharge_width_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> (hi_cnt >= CW'(T_RP)));

    // R10: first CAS after activation respects T_RCD
    p_ras_to_cas_r10: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && any_cas && !$past(~lcas_n | ~ucas_n)) |-> (lo_cnt >= CW'(T_RCD)));

    // R7: CAS low with RAS high is a refresh, with WE high and bus idle
    p_cbr_clean_r7: assert property (@(posedge clk) disable iff (rst)
        (ras_n && any_cas) |-> (we_n && !dq_oe));

    // R8: a pending refresh blocks host acceptance
    p_refresh_blocks_host_r8: assert property (@(posedge clk) disable iff (rst)
        ref_pend |-> !req_ready);

    // R4: read data pulse is one cycle wide
    p_rvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |=> !rdata_valid);

    // R1: address held while a CAS stays low with the row open
    p_col_stable_r1: assert property (@(posedge clk) disable iff (rst)
        (!ras_n && !lcas_n && $past(!lcas_n)) |-> $stable(addr));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(.T_RCD(T_RCD), .T_RP(T_RP)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ras_n       (dram_ras_n),
    .ucas_n      (dram_ucas_n),
    .lcas_n      (dram_lcas_n),
    .we_n        (dram_we_n),
    .oe_n        (dram_oe_n),
    .dq_oe       (dram_dq_oe),
    .addr        (dram_addr),
    .rdata_valid (rdata_valid),
    .req_ready   (req_ready),
    .ref_pend    (ref_pend)
);

// File: tb/edo_dram_ctrl_tb.sv
`timescale 1ns/1ps
module edo_dram_ctrl_tb;
    localparam int T_RCD = 3, T_CAS = 4, T_RP = 4, REF_I = 1950;
    localparam real TCK = 8.0;

    logic        clk = 1'b0, rst = 1'b1;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [21:0] req_addr = '0;
    logic [1:0]  req_be = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready, rdata_valid;
    logic [15:0] rdata;
    logic [12:0] dram_addr;
    logic        ras_n, ucas_n, lcas_n, we_n, oe_n, dq_oe;
    logic [15:0] dq_out;
    logic [15:0] dq_in = '0;

    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    edo_dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .REF_INTERVAL(REF_I)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rdata(rdata), .rdata_valid(rdata_valid), .dram_addr(dram_addr),
        .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n),
        .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_dq_out(dq_out),
        .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
    );

    // ---------------- behavioural DRAM model ----------------
    logic [15:0] mem [int unsigned];
    logic [12:0] m_row = '0;
    logic [8:0]  m_col = '0;
    logic [1:0]  m_lanes = '0;
    int  n_act = 0, n_ref = 0, ref_bad = 0, wr_bad = 0;
    real t_ras_fall = 0.0, t_ras_rise = -1000.0;
    real min_rp = 1.0e9, min_rcd = 1.0e9, min_cas = 1.0e9, t_lcas_fall = 0.0;
    bit  first_cas = 1'b0;

    always @(negedge ras_n) begin
        if (!lcas_n || !ucas_n) begin
            n_ref++;
            if (!we_n || dq_oe) ref_bad++;
        end else begin
            n_act++;
            m_row = dram_addr;
            first_cas = 1'b1;
        end
        if ($realtime - t_ras_rise < min_rp) min_rp = $realtime - t_ras_rise;
        t_ras_fall = $realtime;
    end

    always @(posedge ras_n) t_ras_rise = $realtime;

    always @(negedge lcas_n) t_lcas_fall = $realtime;
    always @(posedge lcas_n) if (!ras_n && (($realtime - t_lcas_fall) < min_cas))
        min_cas = $realtime - t_lcas_fall;

    always @(negedge lcas_n or negedge ucas_n) begin
        #1;
        if (!ras_n) begin
            int unsigned k;
            logic [15:0] w;
            m_col = dram_addr[8:0];
            k = {m_row, m_col};
            if (first_cas && ($realtime - 1.0 - t_ras_fall) < min_rcd)
                min_rcd = $realtime - 1.0 - t_ras_fall;
            first_cas = 1'b0;
            w = mem.exists(k) ? mem[k] : 16'h0000;
            if (!we_n) begin
                if (!oe_n || !dq_oe) wr_bad++;
                m_lanes = {~ucas_n, ~lcas_n};
                if (!lcas_n) w[7:0]  = dq_out[7:0];
                if (!ucas_n) w[15:8] = dq_out[15:8];
                mem[k] = w;
            end else begin
                #19 dq_in = w;
            end
        end
    end

    // ---------------- bench helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic host_req(input bit we, input logic [21:0] a, input logic [1:0] be,
                            input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_be = be; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic host_write(input logic [21:0] a, input logic [1:0] be, input logic [15:0] d);
        host_req(1'b1, a, be, d);
    endtask

    task automatic host_read(input logic [21:0] a, output logic [15:0] d);
        host_req(1'b0, a, 2'b00, 16'h0);
        while (!rdata_valid) @(negedge clk);
        d = rdata;
        @(negedge clk);
        check(!rdata_valid, "R4 rdata_valid width", int'(rdata_valid), 0);
    endtask

    function automatic logic [21:0] mk(input logic [12:0] r, input logic [8:0] c);
        return {r, c};
    endfunction

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        check(ras_n && lcas_n && ucas_n && we_n && oe_n, "R9 strobes in reset",
              {ras_n, ucas_n, lcas_n, we_n, oe_n}, 5'h1f);
        check(!dq_oe && !rdata_valid, "R9 bus/valid in reset", {dq_oe, rdata_valid}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(ras_n && lcas_n && ucas_n && !dq_oe, "R9 idle after reset",
              {ras_n, ucas_n, lcas_n, dq_oe}, 4'he);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        host_write(mk(13'h0123, 9'h045), 2'b11, 16'hA5C3);
        check(m_row == 13'h0123, "R1 row at RAS fall", m_row, 13'h0123);
        check(m_col == 9'h045, "R1 column at CAS fall", m_col, 9'h045);
        host_read(mk(13'h0123, 9'h045), d);
        check(d == 16'hA5C3, "R4 read data", d, 16'hA5C3);
        check(wr_bad == 0, "R3 early write with OE high", wr_bad, 0);
    endtask

    task automatic t_bytes();
        logic [15:0] d;
        logic [21:0] a = mk(13'h0456, 9'h1F0);
        host_write(a, 2'b11, 16'hFFFF);
        host_write(a, 2'b01, 16'h1234);
        check(m_lanes == 2'b01, "R2 low lane only", m_lanes, 2'b01);
        host_read(a, d);
        check(d == 16'hFF34, "R2 low byte write", d, 16'hFF34);
        host_write(a, 2'b10, 16'hAB00);
        check(m_lanes == 2'b10, "R2 high lane only", m_lanes, 2'b10);
        host_read(a, d);
        check(d == 16'hAB34, "R2 high byte write", d, 16'hAB34);
    endtask

    task automatic t_page();
        logic [15:0] d;
        int a0, r0;
        a0 = n_act; r0 = n_ref;
        for (int i = 0; i < 4; i++) host_write(mk(13'h0777, 9'(i * 3)), 2'b11, 16'(16'h5000 + i));
        for (int i = 0; i < 4; i++) begin
            host_read(mk(13'h0777, 9'(i * 3)), d);
            check(d == 16'(16'h5000 + i), "R5 page data", d, 16'h5000 + i);
        end
        check((n_act - a0) >= 1 && (n_act - a0) <= 1 + (n_ref - r0), "R5 single activation",
              n_act - a0, 1);
    endtask

    task automatic t_miss();
        logic [15:0] d;
        int a0;
        host_write(mk(13'h0010, 9'h001), 2'b11, 16'h1111);
        host_write(mk(13'h0020, 9'h001), 2'b11, 16'h2222);
        a0 = n_act;
        host_read(mk(13'h0010, 9'h001), d);
        check(d == 16'h1111, "R6 miss data row A", d, 16'h1111);
        host_read(mk(13'h0020, 9'h001), d);
        check(d == 16'h2222, "R6 miss data row B", d, 16'h2222);
        host_read(mk(13'h0010, 9'h001), d);
        check(n_act - a0 == 3, "R6 activation per miss", n_act - a0, 3);
        check(min_rp >= T_RP * TCK, "R6 precharge width", int'(min_rp), T_RP * 8);
    endtask

    task automatic t_refresh_idle();
        int r0;
        r0 = n_ref;
        repeat (5 * REF_I) @(negedge clk);
        check((n_ref - r0) >= 4 && (n_ref - r0) <= 6, "R7 refresh rate", n_ref - r0, 5);
        check(ref_bad == 0, "R7 CBR strobes clean", ref_bad, 0);
    endtask

    task automatic t_refresh_load();
        logic [15:0] d;
        int r0, cyc;
        r0 = n_ref;
        host_write(mk(13'h0100, 9'h00A), 2'b11, 16'hC0DE);
        host_write(mk(13'h0200, 9'h00B), 2'b11, 16'hBEEF);
        cyc = 0;
        while (cyc < 4 * REF_I) begin
            host_read(mk(13'h0100, 9'h00A), d);
            if (d != 16'hC0DE) check(1'b0, "R8 data under refresh", d, 16'hC0DE);
            host_read(mk(13'h0200, 9'h00B), d);
            if (d != 16'hBEEF) check(1'b0, "R8 data under refresh", d, 16'hBEEF);
            cyc += 40;
        end
        check((n_ref - r0) >= 3, "R8 refresh pre-empts traffic", n_ref - r0, 4);
        check(d == 16'hBEEF, "R8 last read intact", d, 16'hBEEF);
    endtask

    task automatic t_timing();
        check(min_rcd >= T_RCD * TCK, "R10 RAS to CAS delay", int'(min_rcd), T_RCD * 8);
        check(min_cas >= T_CAS * TCK - 0.01 && min_cas <= T_CAS * TCK + 0.01,
              "R10 CAS low width", int'(min_cas), T_CAS * 8);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_basic();
        t_bytes();
        t_page();
        t_miss();
        t_refresh_idle();
        t_refresh_load();
        t_timing();
        report();
    end

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        report();
    end
endmodule